// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block models a synchronous static memory of 36-bit words whose depth is set by a parameter. Each enabled rising clock edge registers a command: an address, a read-or-write select, three chip selects and a load-or-continue strobe. The data transfer for that command takes place in the clock cycle that follows. The read path has no output register. During the data cycle of a read, the word comes straight from the array onto the data-out lines. Because every command's data phase lags it by exactly one cycle, a stream can switch between reads and writes on every cycle without an idle cycle on the bus.

A separate burst address generator may feed the address input. When the load-or-continue strobe is high, the block continues the operation already in flight at the address now presented. It ignores the select inputs and the read-or-write input. When the strobe is low, a new operation starts only if all three chip selects are asserted. Otherwise the block goes idle, and the transfer already pending still finishes. The active-low stall input freezes every register. An asynchronous output enable can release the data bus at any moment. The bus is split into separate data-in, data-out and drive-enable signals.

Top module: `zbt_sram`

## Requirements
- R1: While `rst_n` is low and after it is released, no operation is pending and `dq_oe` is 0 until a read is loaded.
- R2: On an edge with `cke_n`=0, `adv_ld`=0, `sel1_n`=0, `sel2`=1, `sel3_n`=0 and `rd_wrn`=1, a read of `addr` is registered. Throughout the next cycle, `dq_oe`=1 (when `oe_n`=0) and `dq_out` holds the stored word, with no output register in between.
- R3: A write is loaded the same way with `rd_wrn`=0. The word on `dq_in` at the next edge with `cke_n`=0 is stored at the address captured with the command.
- R4: Reads and writes may alternate on consecutive edges with no idle cycle. A read loaded on the edge that stores a write to the same address returns the new word.
- R5: `oe_n`=1 forces `dq_oe` to 0 at once, whatever is pending.
- R6: On an edge with `cke_n`=1, every input is ignored and all state holds. A pending read keeps driving the same word, a pending write does not store, and no new command is captured.
- R7: On an enabled edge with `adv_ld`=0 and any chip select inactive, no operation starts and `dq_oe` is 0 in the following cycle. A pending write still stores its data on that edge.
- R8: On an enabled edge with `adv_ld`=1, the block continues the current operation type at the new `addr` and ignores the chip selects and `rd_wrn`. If the block is idle, it stays idle.
- R9: During the data cycle of a write, `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the command register |
| cke_n | input | 1 | Active-low clock enable; 1 stalls the block |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 loads a new command, 1 continues the current one |
| rd_wrn | input | 1 | 1 selects read, 0 selects write |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | DATA_W | Write data, sampled at the edge that ends the data cycle |
| dq_out | output | DATA_W | Flow-through read data |
| dq_oe | output | 1 | High when the block drives the data bus |

## Verification
The properties assume that reset is held for at least one clock edge before any command, and that every input is at a defined level at each sampled edge. The bench changes all inputs only on falling edges. It reads back only addresses that it has already written, so every word it compares is defined. The checks on the read data assume `oe_n` stays low during the data cycle. The bench raises `oe_n` only on the cycles it uses to exercise forced release of the bus.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

    function automatic logic chip_selected(input logic s1_n, input logic s2, input logic s3_n);
        return !s1_n && s2 && !s3_n;
    endfunction

endpackage

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              sel1_n,
    input  logic              sel2,
    input  logic              sel3_n,
    input  logic              adv_ld,
    input  logic              rd_wrn,
    input  logic [ADDR_W-1:0] addr,
    output logic              cmd_valid,
    output op_e               cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              wr_commit
);

    typedef struct packed {
        logic              valid;
        op_e               op;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    cmd_t cmd_d, cmd_q;

    always_comb begin
        cmd_d = cmd_q;
        if (!cke_n) begin
            if (!adv_ld) begin
                // new command, or deselect
                cmd_d.valid = chip_selected(sel1_n, sel2, sel3_n);
                cmd_d.op    = rd_wrn ? OP_READ : OP_WRITE;
                cmd_d.addr  = addr;
            end else begin
                // continue current operation at the externally advanced address
                cmd_d.addr  = addr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '{valid: 1'b0, op: OP_READ, addr: '0};
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign cmd_valid = cmd_q.valid;
    assign cmd_op    = cmd_q.op;
    assign cmd_addr  = cmd_q.addr;
    assign wr_commit = !cke_n && cmd_q.valid && (cmd_q.op == OP_WRITE);

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] wa,
    input  logic [DATA_W-1:0] wd,
    input  logic [ADDR_W-1:0] ra,
    output logic [DATA_W-1:0] rd
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[wa] <= wd;
        end
    end

    assign rd = mem_q[ra];

endmodule

// File: rtl/zbt_drive.sv
module zbt_drive
    import zbt_pkg::*;
(
    input  logic cmd_valid,
    input  op_e  cmd_op,
    input  logic oe_n,
    output logic dq_oe
);

    always_comb begin
        dq_oe = cmd_valid && (cmd_op == OP_READ) && !oe_n;
    end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              sel1_n,
    input  logic              sel2,
    input  logic              sel3_n,
    input  logic              adv_ld,
    input  logic              rd_wrn,
    input  logic [ADDR_W-1:0] addr,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    logic              cmd_valid;
    op_e               cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic              wr_commit;

    zbt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke_n     (cke_n),
        .sel1_n    (sel1_n),
        .sel2      (sel2),
        .sel3_n    (sel3_n),
        .adv_ld    (adv_ld),
        .rd_wrn    (rd_wrn),
        .addr      (addr),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .wr_commit (wr_commit)
    );

    zbt_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk (clk),
        .we  (wr_commit),
        .wa  (cmd_addr),
        .wd  (dq_in),
        .ra  (cmd_addr),
        .rd  (dq_out)
    );

    zbt_drive u_drive (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .oe_n      (oe_n),
        .dq_oe     (dq_oe)
    );

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke_n,
    input logic              sel1_n,
    input logic              sel2,
    input logic              sel3_n,
    input logic              adv_ld,
    input logic              rd_wrn,
    input logic              oe_n,
    input logic              dq_oe,
    input logic              cmd_valid,
    input op_e               cmd_op,
    input logic [ADDR_W-1:0] cmd_addr
);

    logic sel;
    assign sel = chip_selected(sel1_n, sel2, sel3_n);

    assert_read_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && sel && rd_wrn) |=> (oe_n || dq_oe));

    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(cmd_valid) && $stable(cmd_op) && $stable(cmd_addr)));

    assert_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && !sel) |=> !dq_oe);

    assert_continue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_ld) |=> (cmd_valid == $past(cmd_valid) && cmd_op == $past(cmd_op)));

    assert_write_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && sel && !rd_wrn) |=> !dq_oe);

endmodule

bind zbt_sram zbt_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke_n     (cke_n),
    .sel1_n    (sel1_n),
    .sel2      (sel2),
    .sel3_n    (sel3_n),
    .adv_ld    (adv_ld),
    .rd_wrn    (rd_wrn),
    .oe_n      (oe_n),
    .dq_oe     (dq_oe),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr)
);

// File: tb/zbt_sram_test.sv
module zbt_sram_test;

    localparam int AW = 10;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke_n = 1'b0;
    logic          sel1_n = 1'b1;
    logic          sel2 = 1'b0;
    logic          sel3_n = 1'b1;
    logic          adv_ld = 1'b0;
    logic          rd_wrn = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    zbt_sram #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sel1_n(sel1_n), .sel2(sel2),
        .sel3_n(sel3_n), .adv_ld(adv_ld), .rd_wrn(rd_wrn), .addr(addr),
        .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    typedef struct {
        logic          oe;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    exp_t          sb_q[$];
    logic [DW-1:0] ref_mem [1 << AW];
    bit            p_valid = 1'b0;
    bit            p_write = 1'b0;
    int            p_addr = 0;

    function automatic logic [DW-1:0] pat(input int i);
        return {4'hA, 32'(i) * 32'h0101_0107 + 32'h5A};
    endfunction

    // driver: one call per clock cycle, inputs change on the falling edge
    task automatic cyc(input bit ck_n, input bit s1n, input bit s2, input bit s3n,
                       input bit adv, input bit rw, input int a,
                       input logic [DW-1:0] din, input bit oen, input string tag);
        exp_t e;
        @(negedge clk);
        cke_n = ck_n; sel1_n = s1n; sel2 = s2; sel3_n = s3n;
        adv_ld = adv; rd_wrn = rw; addr = AW'(a); dq_in = din; oe_n = oen;
        if (!ck_n) begin
            if (p_valid && p_write) ref_mem[p_addr] = din;
            if (!adv) begin
                p_valid = !s1n && s2 && !s3n;
                p_write = !rw;
                p_addr  = a;
            end else begin
                p_addr  = a;
            end
        end
        e.oe   = p_valid && !p_write && !oen;
        e.data = ref_mem[p_addr];
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    task automatic wr(input int a, input logic [DW-1:0] din, input string tag);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, a, din, 1'b0, tag);
    endtask

    task automatic rd(input int a, input logic [DW-1:0] din, input bit oen, input string tag);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, a, din, oen, tag);
    endtask

    task automatic desel(input logic [DW-1:0] din, input string tag);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 0, din, 1'b0, tag);
    endtask

    // continue: selects off and write requested, both must be ignored
    task automatic cont(input int a, input logic [DW-1:0] din, input string tag);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, a, din, 1'b0, tag);
    endtask

    // stall: a full write load on the pins, all of it to be ignored
    task automatic stall(input string tag);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5, 36'hF_DEAD_BEEF, 1'b0, tag);
    endtask

    // monitor: samples 5 ns after each rising edge
    always @(posedge clk) begin
        exp_t e;
        #5;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            checks++;
            if (dq_oe !== e.oe) begin
                errors++;
                $display("FAIL %s: dq_oe actual=%b expected=%b", e.tag, dq_oe, e.oe);
            end else if (e.oe && dq_out !== e.data) begin
                errors++;
                $display("FAIL %s: dq_out actual=%h expected=%h", e.tag, dq_out, e.data);
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (dq_oe !== 1'b0) begin
            errors++;
            $display("FAIL R1: dq_oe actual=%b expected=0", dq_oe);
        end
        rst_n = 1'b1;
        desel('0, "R1");
        desel('0, "R1");

        // R3 / R9: back-to-back writes, data follows each command by one edge
        wr(0, '0, "R9");
        for (int i = 1; i < 8; i++) wr(i, pat(i - 1), "R9");
        // R2: reads of written words, the first also supplies the last write's data
        rd(0, pat(7), 1'b0, "R3");
        for (int i = 1; i < 8; i++) rd(i, '0, 1'b0, "R2");

        // R4: write then read of the same address on consecutive edges
        for (int i = 0; i < 16; i++) begin
            wr(100 + i, '0, "R4");
            rd(100 + i, pat(100 + i), 1'b0, "R4");
        end
        for (int i = 0; i < 8; i++) rd(i, '0, 1'b0, "R4");

        // R5: output enable released during a read data cycle
        rd(3, '0, 1'b1, "R5");
        rd(3, '0, 1'b0, "R5");

        // R6: stall while a read is pending, then check addr 5 untouched
        rd(4, '0, 1'b0, "R6");
        stall("R6");
        stall("R6");
        stall("R6");
        rd(5, '0, 1'b0, "R6");
        // R6: stall while a write is pending, data taken at the next enabled edge
        wr(6, '0, "R6");
        stall("R6");
        stall("R6");
        rd(6, 36'h3_1234_5678, 1'b0, "R6");
        rd(5, '0, 1'b0, "R6");

        // R8 then R7: read burst continued, deselected mid-burst
        rd(100, '0, 1'b0, "R8");
        cont(101, '0, "R8");
        cont(102, '0, "R8");
        cont(103, '0, "R8");
        desel('0, "R7");
        cont(104, '0, "R8");
        desel('0, "R8");

        // R8 then R7: write burst, deselect lets the last write finish
        wr(200, '0, "R9");
        cont(201, 36'h1_1111_0200, "R8");
        cont(202, 36'h2_2222_0201, "R8");
        desel(36'h3_3333_0202, "R7");
        rd(202, '0, 1'b0, "R7");
        rd(201, '0, 1'b0, "R8");
        rd(200, '0, 1'b0, "R8");
        desel('0, "R7");
        desel('0, "R7");

        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule